// File: doc/BRIEF.md
# Atomic Synchronization Unit for a Shared Word Memory

This unit sits in front of a small word memory that several requesters share, and it gives them indivisible primitives for building locks and counters. Each requester presents an operation code, a word address and write data on its own request lanes. A round-robin arbiter picks one request per cycle, and the unit performs the whole read-modify-write on that one word within the same cycle. The response follows one cycle later. Depending on the operation, it carries either the word's earlier value or a success flag.

Five primitives are provided: exchange, test-and-set, fetch-and-increment, and a linked load paired with a conditional store. Each requester owns one reservation register that holds a valid bit and an address. A linked load fills this register. Any write that lands on the reserved address clears it, whichever requester made the write. A conditional store uses up the reservation whether or not it succeeds. For lock use, 0 means free and 1 means taken. An exchange of 1 that returns 0 means the lock was acquired.

Top module: `atomic_sync_unit`

## Requirements
- R1: After reset every memory word reads 0, no response is valid, and no requester holds a reservation, so a conditional store issued first returns 0.
- R2: Op code 0 (exchange) writes the request data into the addressed word and returns the word's earlier value.
- R3: Op code 1 (test-and-set) returns the earlier value and writes the request data only when that earlier value is 0. A nonzero word is left unchanged.
- R4: Op code 2 (fetch-and-increment) returns the earlier value and stores that value plus one, modulo 2^DW, so all-ones wraps to 0.
- R5: Op code 3 (linked load) returns the word's value without changing memory and sets the requester's reservation to that address, replacing any earlier one.
- R6: Op code 4 (conditional store) succeeds only when the requester holds a valid reservation on the same address. It then writes the data and returns 1. Otherwise it writes nothing and returns 0.
- R7: Every write to an address clears the reservations of all requesters on that address, whether the write comes from exchange, test-and-set, increment or conditional store. Reservations on other addresses survive.
- R8: A conditional store clears the issuing requester's reservation whether it succeeds or fails, so a second conditional store without a new linked load fails.
- R9: At most one request is granted per cycle, only a requester with its valid bit set is granted, and the search begins at the requester after the last one granted.
- R10: Exactly one cycle after each grant, rsp_vld is 1 and rsp_id names the granted requester. rsp_vld is 0 in cycles that follow no grant.
- R11: Op codes 5 to 7 return the word's value and change neither memory nor any reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NREQ | Per-requester request valid |
| req_op | input | 3*NREQ | Per-requester op code, requester k in bits [3k+2:3k] |
| req_addr | input | AW*NREQ | Per-requester word address |
| req_wdata | input | DW*NREQ | Per-requester write data |
| gnt | output | NREQ | One-hot grant, the request is consumed at this clock edge |
| rsp_vld | output | 1 | Response valid |
| rsp_id | output | $clog2(NREQ) | Requester that the response belongs to |
| rsp_data | output | DW | Earlier word value, or 0/1 for a conditional store |

## Verification
The case that is hardest to reach from the ports is a reservation that another requester's write silently cancels between a linked load and its conditional store. This is especially hard to reach when that write is a failed test-and-set, which must leave the reservation intact, or a write to a neighbouring address. Directed sequences build each of these interleavings explicitly. A long random phase then confines all traffic to four addresses and four requesters, so that linked loads, stores and increments collide often, and every response is compared against a reference model of memory and reservations kept in the bench. A burst in which all requesters ask at once checks the rotation of grants and the order in which a shared counter is incremented.

// File: rtl/atomic_sync_pkg.sv
package atomic_sync_pkg;
  typedef enum logic [2:0] {
    OP_SWAP = 3'd0,
    OP_TAS  = 3'd1,
    OP_FINC = 3'd2,
    OP_LL   = 3'd3,
    OP_SC   = 3'd4
  } sync_op_e;
  localparam int OPW = 3;
endpackage

// File: rtl/sync_rr_arbiter.sv
module sync_rr_arbiter #(
  parameter int NREQ = 4,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] valid,
  output logic [NREQ-1:0] gnt,
  output logic [IDW-1:0]  gnt_idx,
  output logic            gnt_any
);
  logic [IDW-1:0] ptr_q, ptr_d;
  logic           ptr_en;

  always_comb begin
    int j;
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < NREQ; k++) begin
      j = int'(ptr_q) + k;
      if (j >= NREQ) j = j - NREQ;
      if (!gnt_any && valid[j]) begin
        gnt_any = 1'b1;
        gnt_idx = IDW'(j);
      end
    end
    if (gnt_any) gnt[gnt_idx] = 1'b1;
  end

  always_comb begin
    ptr_en = gnt_any;
    if (int'(gnt_idx) == NREQ - 1) ptr_d = '0;
    else                           ptr_d = gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/sync_rmw_unit.sv
module sync_rmw_unit
  import atomic_sync_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  old_val,
  input  logic [DW-1:0]  wdata,
  input  logic           sc_ok,
  output logic           we,
  output logic [DW-1:0]  new_val,
  output logic [DW-1:0]  rdata,
  output logic           is_ll,
  output logic           is_sc
);
  always_comb begin
    we      = 1'b0;
    new_val = wdata;
    rdata   = old_val;
    is_ll   = 1'b0;
    is_sc   = 1'b0;
    case (sync_op_e'(op))
      OP_SWAP: we = 1'b1;
      OP_TAS:  we = (old_val == '0);
      OP_FINC: begin
        we      = 1'b1;
        new_val = old_val + 1'b1;
      end
      OP_LL:   is_ll = 1'b1;
      OP_SC: begin
        is_sc = 1'b1;
        we    = sc_ok;
        rdata = {{(DW-1){1'b0}}, sc_ok};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sync_resv_table.sv
module sync_resv_table #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           act,
  input  logic [IDW-1:0] id,
  input  logic [AW-1:0]  addr,
  input  logic           is_ll,
  input  logic           is_sc,
  input  logic           we,
  output logic           sc_ok
);
  logic [NREQ-1:0] rv_q, rv_d;
  logic [AW-1:0]   ra_q [NREQ];
  logic [AW-1:0]   ra_d [NREQ];
  logic            upd;

  assign sc_ok = rv_q[id] && (ra_q[id] == addr);
  assign upd   = act;

  always_comb begin
    for (int k = 0; k < NREQ; k++) begin
      rv_d[k] = rv_q[k];
      ra_d[k] = ra_q[k];
      if (we && rv_q[k] && ra_q[k] == addr) rv_d[k] = 1'b0;
      if (int'(id) == k) begin
        if (is_ll) begin
          rv_d[k] = 1'b1;
          ra_d[k] = addr;
        end
        if (is_sc) rv_d[k] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= '0;
      for (int k = 0; k < NREQ; k++) ra_q[k] <= '0;
    end else if (upd) begin
      rv_q <= rv_d;
      for (int k = 0; k < NREQ; k++) ra_q[k] <= ra_d[k];
    end
  end
endmodule

// File: rtl/atomic_sync_unit.sv
module atomic_sync_unit
  import atomic_sync_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16,
  localparam int IDW   = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     req_valid,
  input  logic [OPW*NREQ-1:0] req_op,
  input  logic [AW*NREQ-1:0]  req_addr,
  input  logic [DW*NREQ-1:0]  req_wdata,
  output logic [NREQ-1:0]     gnt,
  output logic                rsp_vld,
  output logic [IDW-1:0]      rsp_id,
  output logic [DW-1:0]       rsp_data
);
  logic [1:0]      rst_pipe;
  logic            rst_sn;
  logic [NREQ-1:0] valid_live;
  logic [IDW-1:0]  sel;
  logic            any;
  logic [OPW-1:0]  s_op;
  logic [AW-1:0]   s_addr;
  logic [DW-1:0]   s_wdata;
  logic [DW-1:0]   old_val, new_val, rdata;
  logic            we, we_g, sc_ok, is_ll, is_sc;
  logic [DW-1:0]   mem_q [DEPTH];
  logic            rsp_vld_d;
  logic [IDW-1:0]  rsp_id_d;
  logic [DW-1:0]   rsp_data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn     = rst_pipe[1];
  assign valid_live = rst_sn ? req_valid : '0;

  sync_rr_arbiter #(.NREQ(NREQ)) u_arb (
    .clk(clk), .rst_n(rst_sn), .valid(valid_live),
    .gnt(gnt), .gnt_idx(sel), .gnt_any(any)
  );

  always_comb begin
    s_op    = req_op[sel*OPW +: OPW];
    s_addr  = req_addr[sel*AW +: AW];
    s_wdata = req_wdata[sel*DW +: DW];
    old_val = mem_q[s_addr];
  end

  sync_rmw_unit #(.DW(DW)) u_rmw (
    .op(s_op), .old_val(old_val), .wdata(s_wdata), .sc_ok(sc_ok),
    .we(we), .new_val(new_val), .rdata(rdata), .is_ll(is_ll), .is_sc(is_sc)
  );

  assign we_g = we && any;

  sync_resv_table #(.NREQ(NREQ), .AW(AW)) u_resv (
    .clk(clk), .rst_n(rst_sn), .act(any), .id(sel), .addr(s_addr),
    .is_ll(is_ll), .is_sc(is_sc), .we(we_g), .sc_ok(sc_ok)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (we_g) begin
      mem_q[s_addr] <= new_val;
    end
  end

  always_comb begin
    rsp_vld_d  = any;
    rsp_id_d   = sel;
    rsp_data_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_vld  <= 1'b0;
      rsp_id   <= '0;
      rsp_data <= '0;
    end else begin
      rsp_vld <= rsp_vld_d;
      if (any) begin
        rsp_id   <= rsp_id_d;
        rsp_data <= rsp_data_d;
      end
    end
  end
endmodule

// File: rtl/atomic_sync_chk.sv
module atomic_sync_chk
  import atomic_sync_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int DW   = 16,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NREQ-1:0]     req_valid,
  input logic [OPW*NREQ-1:0] req_op,
  input logic [NREQ-1:0]     gnt,
  input logic                rsp_vld,
  input logic [IDW-1:0]      rsp_id,
  input logic [DW-1:0]       rsp_data
);
  logic [IDW-1:0] g_idx;
  logic [OPW-1:0] g_op;

  always_comb begin
    g_idx = '0;
    for (int k = 0; k < NREQ; k++)
      if (gnt[k]) g_idx = IDW'(k);
    g_op = req_op[g_idx*OPW +: OPW];
  end

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R9
  gnt_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req_valid) == '0);
  // R10
  rsp_follows_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |=> (rsp_vld && rsp_id == $past(g_idx)));
  // R10
  no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> !rsp_vld);
  // R6
  sc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && g_op == OP_SC) |=> (rsp_data <= 1));
endmodule

bind atomic_sync_unit atomic_sync_chk #(.NREQ(NREQ), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sn), .req_valid(valid_live), .req_op(req_op),
  .gnt(gnt), .rsp_vld(rsp_vld), .rsp_id(rsp_id), .rsp_data(rsp_data)
);

// File: tb/tb_atomic_sync_unit.sv
module tb_atomic_sync_unit;
  localparam int NREQ = 4;
  localparam int AW   = 4;
  localparam int DW   = 16;
  localparam int IDW  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NREQ-1:0]   req_valid = '0;
  logic [3*NREQ-1:0] req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_wdata = '0;
  logic [NREQ-1:0]   gnt;
  logic              rsp_vld;
  logic [IDW-1:0]    rsp_id;
  logic [DW-1:0]     rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [DW-1:0] m_mem [1<<AW];
  logic          m_rv  [NREQ];
  logic [AW-1:0] m_ra  [NREQ];
  int            m_ptr;

  atomic_sync_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .gnt(gnt),
    .rsp_vld(rsp_vld), .rsp_id(rsp_id), .rsp_data(rsp_data)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference model: returns expected response data and updates state
  function automatic int model(input int id, input int op, input int a, input int wd);
    int old;
    int res;
    bit wr;
    int nv;
    old = int'(m_mem[a]);
    res = old; wr = 0; nv = wd;
    case (op)
      0: wr = 1;
      1: wr = (old == 0);
      2: begin wr = 1; nv = (old + 1) & 16'hFFFF; end
      3: begin m_rv[id] = 1; m_ra[id] = AW'(a); end
      4: begin
        res = (m_rv[id] && int'(m_ra[id]) == a) ? 1 : 0;
        wr = (res == 1);
        m_rv[id] = 0;
      end
      default: ;
    endcase
    if (wr) begin
      m_mem[a] = DW'(nv);
      for (int k = 0; k < NREQ; k++)
        if (m_rv[k] && int'(m_ra[k]) == a) m_rv[k] = 0;
    end
    m_ptr = (id + 1) % NREQ;
    return res;
  endfunction

  task automatic set_req(input int id, input int op, input int a, input int wd);
    req_valid[id] = 1'b1;
    req_op[id*3 +: 3] = 3'(op);
    req_addr[id*AW +: AW] = AW'(a);
    req_wdata[id*DW +: DW] = DW'(wd);
  endtask

  // issue one request at a negedge; check response one negedge later
  task automatic do_op(input int id, input int op, input int a, input int wd,
                       input string req, output int got);
    int exp;
    set_req(id, op, a, wd);
    exp = model(id, op, a, wd);
    @(negedge clk);
    req_valid[id] = 1'b0;
    check({req, " vld"}, int'(rsp_vld), 1);
    check({req, " id"}, int'(rsp_id), id);
    check({req, " data"}, int'(rsp_data), exp);
    got = int'(rsp_data);
  endtask

  initial begin
    int g;
    int order [NREQ];
    void'($urandom(32'd20250607));
    for (int k = 0; k < (1<<AW); k++) m_mem[k] = '0;
    for (int k = 0; k < NREQ; k++) begin m_rv[k] = 0; m_ra[k] = '0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs, memory zero, no reservation
    check("R1 rsp_vld idle", int'(rsp_vld), 0);
    check("R1 gnt idle", int'(gnt), 0);
    do_op(0, 4, 5, 16'h1234, "R1 sc after reset", g);
    do_op(1, 3, 5, 0, "R1 mem zero", g);

    // R2: lock acquire with exchange, second exchange sees taken
    do_op(0, 0, 2, 1, "R2 swap acquire", g);
    check("R2 acquired", g, 0);
    do_op(1, 0, 2, 1, "R2 swap busy", g);
    check("R2 busy", g, 1);

    // R3: test-and-set on taken word leaves it, on free word writes
    do_op(2, 1, 2, 16'h00AA, "R3 tas taken", g);
    do_op(2, 3, 2, 0, "R3 tas no write", g);
    check("R3 still 1", g, 1);
    do_op(3, 1, 7, 16'h0055, "R3 tas free", g);
    do_op(3, 6, 7, 0, "R3 tas wrote", g);
    check("R3 value", g, 16'h0055);

    // R4: increment and wrap
    do_op(0, 0, 9, 16'hFFFF, "R4 preset", g);
    do_op(1, 2, 9, 0, "R4 finc old", g);
    do_op(1, 5, 9, 0, "R4 wrapped", g);
    check("R4 wrap zero", g, 0);

    // R5/R6: LL then SC success, then plain fail
    do_op(2, 3, 4, 0, "R5 ll", g);
    do_op(2, 4, 4, 16'h0BEE, "R6 sc ok", g);
    check("R6 sc success", g, 1);
    do_op(2, 7, 4, 0, "R6 sc wrote", g);
    check("R6 mem", g, 16'h0BEE);
    // R8: second SC without LL fails
    do_op(2, 4, 4, 16'h0DEF, "R8 sc again", g);
    check("R8 fails", g, 0);
    // R5: new LL replaces old; SC to old address fails, no write
    do_op(3, 3, 10, 0, "R5 ll a", g);
    do_op(3, 3, 11, 0, "R5 ll b", g);
    do_op(3, 4, 10, 16'h0777, "R5 sc old addr", g);
    check("R5 replaced", g, 0);
    do_op(3, 5, 10, 0, "R6 no write", g);
    check("R6 unchanged", g, 0);

    // R7: intervening writes by others clear; other address and failed tas do not
    do_op(0, 3, 12, 0, "R7 ll r0", g);
    do_op(1, 3, 12, 0, "R7 ll r1", g);
    do_op(2, 2, 13, 0, "R7 finc other addr", g);
    do_op(3, 0, 12, 1, "R7 swap same addr", g);
    do_op(0, 4, 12, 16'h0044, "R7 sc r0 cleared", g);
    check("R7 r0 fail", g, 0);
    do_op(1, 4, 12, 16'h0045, "R7 sc r1 cleared", g);
    check("R7 r1 fail", g, 0);
    do_op(0, 3, 13, 0, "R7 ll r0 b", g);
    do_op(1, 1, 13, 5, "R7 tas nonzero", g);
    do_op(2, 6, 13, 0, "R11 read", g);
    do_op(0, 4, 13, 16'h0099, "R7 survives failed tas", g);
    check("R7 sc ok", g, 1);

    // R9/R10: all requesters increment one counter at once
    for (int k = 0; k < NREQ; k++) set_req(k, 2, 14, 0);
    for (int k = 0; k < NREQ; k++) order[k] = (m_ptr + k) % NREQ;
    for (int k = 0; k < NREQ; k++) begin
      int e;
      e = model(order[k], 2, 14, 0);
      @(negedge clk);
      req_valid[rsp_id] = 1'b0;
      check("R9 order", int'(rsp_id), order[k]);
      check("R10 vld", int'(rsp_vld), 1);
      check("R9 counter", int'(rsp_data), e);
    end
    @(negedge clk);
    check("R10 idle after burst", int'(rsp_vld), 0);

    // random phase on four addresses
    for (int n = 0; n < 600; n++) begin
      int id, op, a, wd, r;
      id = int'($urandom % NREQ);
      r  = int'($urandom % 16);
      op = (r < 3) ? 0 : (r < 5) ? 1 : (r < 7) ? 2 : (r < 11) ? 3 : (r < 15) ? 4 : 5 + int'($urandom % 3);
      a  = int'($urandom % 4);
      wd = (($urandom % 2) == 0) ? int'($urandom % 3) : int'($urandom & 16'hFFFF);
      do_op(id, op, a, wd, "R2-R8 R11 random", g);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule